// File: doc/BRIEF.md
# Open-Page DRAM Address Sequencer

This block turns single read or write requests, each carrying one flat physical address, into strobe sequences for a four-bank DRAM device. The device has an asynchronous-style interface: one shared, time-multiplexed address bus, a bank select, and active-low row strobe (`ras_n`), column strobe (`cas_n`) and write enable (`we_n`). The block remembers which row is open in each bank, and every bank keeps that state separately. A request that lands on the open row of its bank is served with a column strobe alone. A request to a bank with no open row activates the row first. A request to a bank whose open row differs precharges that bank, activates the new row, and then strobes the column.

Every phase lasts a fixed number of clock cycles. Three timing inputs set these lengths: precharge, row-to-column delay and column hold. Requests arrive over a valid/ready handshake. The block takes one request at a time and signals the end of each access with a one-cycle `done` pulse. The timing inputs are meant to be held steady while a request is in progress.

Top module: `dram_page_seq`

## Requirements
- R1: The request address splits into bank = bits [26:25], row = bits [24:11] and column = bits [10:0]. The row appears on `dram_addr` during row activation, and the column, zero-extended to 14 bits, appears during the column phase. `dram_ba` carries the bank during the precharge, activation and column phases and is 0 at all other times.
- R2: After reset, `req_ready` is 1, `ras_n`, `cas_n` and `we_n` are 1, `done` is 0, `dram_addr` is 0, and every bank counts as having no open row.
- R3: A request to a bank with no open row skips precharge. It holds `ras_n` low for max(`t_rcd`,1) cycles of activation, then keeps `ras_n` low together with `cas_n` low for max(`t_cas`,1) cycles.
- R4: A request whose row equals the open row of its bank drives `cas_n` low for max(`t_cas`,1) cycles, and `ras_n` stays high for the whole access.
- R5: A request to an open bank with a different row first spends max(`t_prech`,1) cycles with all strobes high and `dram_ba` set to that bank. It then runs activation and the column phase as in R3, and the new row becomes the open row of that bank.
- R6: Opening or changing a row in one bank leaves the open row of every other bank unchanged.
- R7: `we_n` is low for every cycle of the column phase of a write and high in every other cycle.
- R8: `done` is high for exactly one cycle, the cycle right after the last column-phase cycle. `req_ready` returns to 1 in the following cycle.
- R9: `req_ready` is 1 only while idle. A request held valid while the block is busy is not taken and leaves the strobes unchanged until `req_ready` is seen high.
- R10: A timing input of 0 behaves like 1, so no phase is ever skipped.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle and able to take a request |
| req_addr | input | 27 | Flat address {bank, row, column} |
| req_write | input | 1 | 1 for a write, 0 for a read |
| t_prech | input | 8 | Precharge length in cycles |
| t_rcd | input | 8 | Row-to-column delay in cycles |
| t_cas | input | 8 | Column strobe hold in cycles |
| dram_addr | output | 14 | Multiplexed row/column address |
| dram_ba | output | 2 | Bank select |
| ras_n | output | 1 | Row strobe, active low |
| cas_n | output | 1 | Column strobe, active low |
| we_n | output | 1 | Write enable, active low |
| done | output | 1 | One-cycle pulse after each completed access |

## Verification
The open-row table is the only state that lives from one request to the next, so a wrong entry shows at the ports on the next request to the affected bank. A stale hit drops the precharge and activation cycles and lets `cas_n` fall in the first busy cycle. A false miss adds a precharge phase and a `ras_n` pulse that should not be there. A wrong phase counter or phase state shows within the same access, as strobes that change one cycle early or late, or as a misplaced `done` pulse. The bench therefore compares every port on every cycle against a behavioural model that keeps its own copy of the open rows, and it revisits banks after other banks have been used.

// File: rtl/dps_pkg.sv
package dps_pkg;

    typedef enum logic [2:0] {
        ST_IDLE = 3'd0,
        ST_PRE  = 3'd1,
        ST_ACT  = 3'd2,
        ST_CAS  = 3'd3,
        ST_DONE = 3'd4
    } seq_state_e;

endpackage

// File: rtl/dps_addr_split.sv
module dps_addr_split #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 11,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W
) (
    input  logic [ADDR_W-1:0] addr,
    output logic [BANK_W-1:0] bank,
    output logic [ROW_W-1:0]  row,
    output logic [COL_W-1:0]  col
);
    // Bank on top, row in the middle, column at the bottom.
    assign col  = addr[COL_W-1:0];
    assign row  = addr[COL_W +: ROW_W];
    assign bank = addr[ADDR_W-1 -: BANK_W];
endmodule

// File: rtl/dps_row_table.sv
module dps_row_table #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 14,
    localparam int BANKS = 1 << BANK_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [BANK_W-1:0] look_bank,
    input  logic [ROW_W-1:0]  look_row,
    output logic              look_open,
    output logic              look_hit,
    input  logic              upd_en,
    input  logic [BANK_W-1:0] upd_bank,
    input  logic [ROW_W-1:0]  upd_row
);
    logic [BANKS-1:0] open_q;
    logic [ROW_W-1:0] row_q [BANKS];

    for (genvar g = 0; g < BANKS; g++) begin : g_bank
        logic             open_d;
        logic [ROW_W-1:0] row_d;

        always_comb begin
            open_d = open_q[g];
            row_d  = row_q[g];
            if (upd_en && upd_bank == BANK_W'(g)) begin
                open_d = 1'b1;
                row_d  = upd_row;
            end
        end

        always_ff @(posedge clk) begin
            if (!rst_n) begin
                open_q[g] <= 1'b0;
                row_q[g]  <= '0;
            end else begin
                open_q[g] <= open_d;
                row_q[g]  <= row_d;
            end
        end
    end

    assign look_open = open_q[look_bank];
    assign look_hit  = open_q[look_bank] && (row_q[look_bank] == look_row);
endmodule

// File: rtl/dram_page_seq.sv
module dram_page_seq #(
    parameter int BANK_W = 2,
    parameter int ROW_W  = 14,
    parameter int COL_W  = 11,
    parameter int CNT_W  = 8,
    localparam int ADDR_W = BANK_W + ROW_W + COL_W,
    localparam int BUS_W  = (ROW_W > COL_W) ? ROW_W : COL_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_write,
    input  logic [CNT_W-1:0]  t_prech,
    input  logic [CNT_W-1:0]  t_rcd,
    input  logic [CNT_W-1:0]  t_cas,
    output logic [BUS_W-1:0]  dram_addr,
    output logic [BANK_W-1:0] dram_ba,
    output logic              ras_n,
    output logic              cas_n,
    output logic              we_n,
    output logic              done
);
    import dps_pkg::*;

    typedef struct packed {
        seq_state_e        st;
        logic [CNT_W-1:0]  cnt;
        logic [BANK_W-1:0] bank;
        logic [ROW_W-1:0]  row;
        logic [COL_W-1:0]  col;
        logic              wr;
        logic              hit;
    } seq_t;

    seq_t s_d, s_q;

    logic [BANK_W-1:0] in_bank;
    logic [ROW_W-1:0]  in_row;
    logic [COL_W-1:0]  in_col;
    logic              lk_open, lk_hit;
    logic              tbl_upd;

    // A phase of N cycles loads N-1; zero is treated as one cycle.
    function automatic logic [CNT_W-1:0] phase_load(input logic [CNT_W-1:0] len);
        return (len == '0) ? '0 : len - 1'b1;
    endfunction

    dps_addr_split #(
        .BANK_W(BANK_W), .ROW_W(ROW_W), .COL_W(COL_W)
    ) u_split (
        .addr (req_addr),
        .bank (in_bank),
        .row  (in_row),
        .col  (in_col)
    );

    dps_row_table #(
        .BANK_W(BANK_W), .ROW_W(ROW_W)
    ) u_table (
        .clk       (clk),
        .rst_n     (rst_n),
        .look_bank (in_bank),
        .look_row  (in_row),
        .look_open (lk_open),
        .look_hit  (lk_hit),
        .upd_en    (tbl_upd),
        .upd_bank  (s_q.bank),
        .upd_row   (s_q.row)
    );

    always_comb begin
        s_d     = s_q;
        tbl_upd = 1'b0;
        unique case (s_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    s_d.bank = in_bank;
                    s_d.row  = in_row;
                    s_d.col  = in_col;
                    s_d.wr   = req_write;
                    s_d.hit  = lk_hit;
                    if (lk_hit) begin
                        s_d.st  = ST_CAS;
                        s_d.cnt = phase_load(t_cas);
                    end else if (lk_open) begin
                        s_d.st  = ST_PRE;
                        s_d.cnt = phase_load(t_prech);
                    end else begin
                        s_d.st  = ST_ACT;
                        s_d.cnt = phase_load(t_rcd);
                    end
                end
            end
            ST_PRE: begin
                if (s_q.cnt == '0) begin
                    s_d.st  = ST_ACT;
                    s_d.cnt = phase_load(t_rcd);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_ACT: begin
                if (s_q.cnt == '0) begin
                    tbl_upd = 1'b1;
                    s_d.st  = ST_CAS;
                    s_d.cnt = phase_load(t_cas);
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_CAS: begin
                if (s_q.cnt == '0) begin
                    s_d.st = ST_DONE;
                end else begin
                    s_d.cnt = s_q.cnt - 1'b1;
                end
            end
            ST_DONE: begin
                s_d.st = ST_IDLE;
            end
            default: begin
                s_d.st = ST_IDLE;
            end
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            s_q <= '{st: ST_IDLE, default: '0};
        end else begin
            s_q <= s_d;
        end
    end

    // Strobe and bus decode from registered state.
    logic in_bus_phase;
    assign in_bus_phase = (s_q.st == ST_PRE) || (s_q.st == ST_ACT) || (s_q.st == ST_CAS);

    assign req_ready = (s_q.st == ST_IDLE);
    assign done      = (s_q.st == ST_DONE);
    assign ras_n     = !((s_q.st == ST_ACT) || (s_q.st == ST_CAS && !s_q.hit));
    assign cas_n     = !(s_q.st == ST_CAS);
    assign we_n      = !(s_q.st == ST_CAS && s_q.wr);
    assign dram_ba   = in_bus_phase ? s_q.bank : '0;

    always_comb begin
        dram_addr = '0;
        if (s_q.st == ST_ACT)      dram_addr = BUS_W'(s_q.row);
        else if (s_q.st == ST_CAS) dram_addr = BUS_W'(s_q.col);
    end
endmodule

// File: rtl/dps_checker.sv
module dps_checker #(
    parameter int BUS_W = 14
) (
    input logic             clk,
    input logic             rst_n,
    input logic             req_valid,
    input logic             req_ready,
    input logic [BUS_W-1:0] dram_addr,
    input logic             ras_n,
    input logic             cas_n,
    input logic             we_n,
    input logic             done
);
    // R7: write enable only ever asserted inside a column strobe
    a_r7_we_inside_cas: assert property (@(posedge clk) disable iff (!rst_n)
        !we_n |-> !cas_n);

    // R8: done lasts one cycle
    a_r8_done_single: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    // R8: done follows a column strobe cycle directly
    a_r8_done_after_cas: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> $past(!cas_n));

    // R9: an accepted request makes the block busy
    a_r9_busy_after_take: assert property (@(posedge clk) disable iff (!rst_n)
        (req_valid && req_ready) |=> !req_ready);

    // R9: idle means no strobes on the device
    a_r9_idle_quiet: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> (ras_n && cas_n && we_n));

    // R1: column address held steady across the column phase
    a_r1_col_steady: assert property (@(posedge clk) disable iff (!rst_n)
        (!cas_n && !$past(cas_n)) |-> $stable(dram_addr));

    // R3: on a row-strobed access, the row strobe led the column strobe
    a_r3_ras_leads_cas: assert property (@(posedge clk) disable iff (!rst_n)
        ($fell(cas_n) && !ras_n) |-> $past(!ras_n));
endmodule

bind dram_page_seq dps_checker #(.BUS_W(BUS_W)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_valid (req_valid),
    .req_ready (req_ready),
    .dram_addr (dram_addr),
    .ras_n     (ras_n),
    .cas_n     (cas_n),
    .we_n      (we_n),
    .done      (done)
);

// File: tb/sim_dram_page_seq.sv
module sim_dram_page_seq;
    localparam time CLK_PERIOD = 10ns;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        req_valid = 1'b0;
    logic        req_ready;
    logic [26:0] req_addr = '0;
    logic        req_write = 1'b0;
    logic [7:0]  t_prech = 8'd2, t_rcd = 8'd2, t_cas = 8'd2;
    logic [13:0] dram_addr;
    logic [1:0]  dram_ba;
    logic        ras_n, cas_n, we_n, done;

    always #(CLK_PERIOD/2) clk = ~clk;

    dram_page_seq u0 (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_addr(req_addr), .req_write(req_write),
        .t_prech(t_prech), .t_rcd(t_rcd), .t_cas(t_cas),
        .dram_addr(dram_addr), .dram_ba(dram_ba),
        .ras_n(ras_n), .cas_n(cas_n), .we_n(we_n), .done(done)
    );

    typedef struct {
        logic [20:0] v;   // {ras_n, cas_n, we_n, ba[1:0], addr[13:0], done, ready}
        string       tag;
    } exp_t;

    exp_t  exp_q[$];
    int    n_checks = 0;
    int    n_fail   = 0;
    bit    running  = 0;
    bit    saw_idle = 0;
    string idle_tag = "R2";

    // Bench copy of the open rows
    bit        m_open [4];
    bit [13:0] m_row  [4];

    function automatic logic [20:0] pack(input bit r, input bit c, input bit w,
                                         input bit [1:0] b, input bit [13:0] a,
                                         input bit d, input bit y);
        return {r, c, w, b, a, d, y};
    endfunction

    function automatic int atleast1(input int x);
        return (x == 0) ? 1 : x;
    endfunction

    task automatic check(input logic [20:0] act, input logic [20:0] expv, input string tag);
        n_checks++;
        if (act !== expv) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h (ras,cas,we,ba,addr,done,ready)",
                     tag, act, expv);
        end
    endtask

    // Compare all ports every cycle, away from the active edge
    always @(negedge clk) begin
        if (running) begin
            logic [20:0] act;
            act = {ras_n, cas_n, we_n, dram_ba, dram_addr, done, req_ready};
            if (exp_q.size() != 0) begin
                exp_t e;
                e = exp_q.pop_front();
                check(act, e.v, e.tag);
                saw_idle = 0;
            end else begin
                check(act, pack(1, 1, 1, 2'd0, 14'd0, 0, 1), idle_tag);
                saw_idle = 1;
            end
        end
    end

    task automatic push(input logic [20:0] v, input string tag);
        exp_t e;
        e.v = v;
        e.tag = tag;
        exp_q.push_back(e);
    endtask

    // Issue one request; "early" raises valid while the block is still busy (R9)
    task automatic issue(input bit [1:0] b, input bit [13:0] r, input bit [10:0] c,
                         input bit wr, input bit early, input string otag);
        bit    hit, opn;
        string tg;
        if (early) begin
            req_valid = 1'b1;
            req_addr  = {b, r, c};
            req_write = wr;
        end
        do begin
            @(negedge clk);
            #1;
        end while (!(exp_q.size() == 0 && saw_idle));
        req_valid = 1'b1;
        req_addr  = {b, r, c};
        req_write = wr;
        opn = m_open[b];
        hit = opn && (m_row[b] == r);
        if (opn && !hit) begin
            tg = (otag != "") ? otag : "R5";
            for (int i = 0; i < atleast1(t_prech); i++)
                push(pack(1, 1, 1, b, 14'd0, 0, 0), tg);
        end
        if (!hit) begin
            tg = (otag != "") ? otag : (opn ? "R5" : "R3");
            for (int i = 0; i < atleast1(t_rcd); i++)
                push(pack(0, 1, 1, b, r, 0, 0), tg);
        end
        tg = (otag != "") ? otag : (wr ? "R7" : (hit ? "R4" : "R1"));
        for (int i = 0; i < atleast1(t_cas); i++)
            push(pack(hit ? 1'b1 : 1'b0, 0, !wr, b, {3'd0, c}, 0, 0), tg);
        push(pack(1, 1, 1, 2'd0, 14'd0, 1, 0), "R8");
        m_open[b] = 1;
        m_row[b]  = r;
        @(negedge clk);
        #1;
        req_valid = 1'b0;
    endtask

    task automatic drain();
        do begin
            @(negedge clk);
            #1;
        end while (!(exp_q.size() == 0 && saw_idle));
    endtask

    // Watchdog
    initial begin
        #(CLK_PERIOD * 100000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog expired");
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end

    initial begin
        for (int i = 0; i < 4; i++) begin
            m_open[i] = 0;
            m_row[i]  = '0;
        end
        repeat (3) @(posedge clk);
        #1 rst_n = 1'b1;
        running = 1;
        // R2: reset state checked by idle comparisons
        repeat (3) @(negedge clk);
        #1 idle_tag = "R9";

        issue(2'd0, 14'd5,   11'd7,    0, 0, "");    // R3 closed bank
        issue(2'd0, 14'd5,   11'd9,    0, 0, "");    // R4 hit
        issue(2'd0, 14'd5,   11'h7FF,  1, 0, "");    // R7 write hit
        issue(2'd1, 14'd100, 11'd3,    0, 0, "");    // R3 other bank
        issue(2'd0, 14'd5,   11'd1,    0, 0, "R6");  // R6 bank0 still open
        issue(2'd0, 14'd6,   11'd2,    1, 0, "");    // R5 miss, write
        issue(2'd3, 14'h3FFF, 11'h7FF, 0, 0, "R1");  // R1 extreme fields
        issue(2'd1, 14'd100, 11'd4,    0, 0, "R6");  // R6 bank1 untouched
        drain();
        t_prech = 8'd0; t_rcd = 8'd0; t_cas = 8'd0;
        issue(2'd0, 14'd7,   11'd4,    0, 0, "R10"); // R10 zeros act as one
        issue(2'd0, 14'd7,   11'd5,    1, 0, "R10");
        drain();
        t_prech = 8'd3; t_rcd = 8'd1; t_cas = 8'd4;
        issue(2'd2, 14'd1,   11'd1,    1, 0, "");
        issue(2'd2, 14'd9,   11'd8,    0, 1, "R9");  // R9 valid held while busy
        issue(2'd3, 14'h3FFF, 11'd0,   0, 1, "R9");
        issue(2'd3, 14'h2AAA, 11'h555, 1, 0, "");
        drain();
        repeat (3) @(negedge clk);
        $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
        $finish;
    end
endmodule